// File: doc/BRIEF.md
# Circle Radius Voting Element

This element is one angle step of a radius estimator for circles whose centre is already known. Each edge pixel that enters is first shifted so that the centre lies at the origin. The element then turns the offset vector through one small fixed angle, using a shift-and-add rotor with no multiplier and no gain correction. The two rotor outputs are the radius seen at that angle and the radius seen a quarter turn later. One adder and one subtractor combine them into the two diagonal radii, which carry a √2 scale. Negating these four values gives the remaining four. Together the eight values cover the whole circle in 45° slices, and each one casts a vote into its own bank of saturating counters.

The rotated coordinate is passed downstream under a valid/ready handshake, so that a further element can apply the next angle step. A host finds the radius by reading the counters through a combinational read port and comparing cells with the same index across elements.

Control is a two-state machine. In `ST_EMPTY` the output register holds nothing and the element always accepts. In `ST_FULL` a rotated coordinate is on offer, and a new pixel is accepted only in a cycle where downstream takes the current one. The transitions are as follows. *fill* goes from EMPTY to FULL on an accepted pixel. *drain* goes from FULL to EMPTY when downstream is ready and no pixel is waiting. *stream* stays in FULL when downstream takes the current result and a new pixel is accepted in the same cycle. *stall* stays in FULL while downstream is not ready.

Top module: `circ_radius_pe`

## Requirements
- R1: After reset every counter in every bank reads 0, `pix_ready` is 1 and `fwd_valid` is 0.
- R2: With X = pix_x − ctr_x and Y = pix_y − ctr_y as signed values, and `>>>` a flooring arithmetic shift by SHIFT, the element forms two values. fwd_x is X − (X >>> (2·SHIFT+1)) + (Y >>> SHIFT). fwd_y is Y − (Y >>> (2·SHIFT+1)) − (X >>> SHIFT). Both appear on the forward port in the cycle after the pixel is accepted.
- R3: Let a = fwd_x and c = fwd_y. Bank k receives a radius as follows: bank 0 gets a, bank 1 gets a+c, bank 2 gets c, bank 3 gets c−a, bank 4 gets −a, bank 5 gets −(a+c), bank 6 gets −c and bank 7 gets −(c−a).
- R4: A radius r that is not negative votes into cell floor(r / 2^BIN_SH) of its bank.
- R5: A negative radius casts no vote in its bank.
- R6: A radius whose cell index is DEPTH or more casts no vote.
- R7: All eight votes of a pixel take effect on its acceptance edge. `rd_count` shows cell `rd_idx` of bank `rd_bank` combinationally, so a read in the acceptance cycle returns the old count and a read in the next cycle returns the new one.
- R8: A counter that holds 2^CNT_W − 1 stays there when it receives further votes.
- R9: A pixel is accepted when `pix_valid` and `pix_ready` are both 1. While `fwd_valid` is 1 and `fwd_ready` is 0, `pix_ready` is 0, the forward data stays unchanged, and the waiting pixel casts no vote.
- R10: The state changes as follows. EMPTY goes to FULL on acceptance. FULL goes to EMPTY when `fwd_ready` is 1 and `pix_valid` is 0. FULL stays FULL on back-to-back pixels. `fwd_valid` is 1 exactly in FULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | PIX_W | Edge pixel column |
| pix_y | input | PIX_W | Edge pixel row |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be taken this cycle |
| ctr_x | input | PIX_W | Circle centre column |
| ctr_y | input | PIX_W | Circle centre row |
| fwd_x | output | PIX_W+2 | Rotated coordinate, first component (signed) |
| fwd_y | output | PIX_W+2 | Rotated coordinate, second component (signed) |
| fwd_valid | output | 1 | Rotated coordinate on offer |
| fwd_ready | input | 1 | Downstream takes the coordinate |
| rd_bank | input | 3 | Bank selected for read-out |
| rd_idx | input | clog2(DEPTH) | Cell selected for read-out |
| rd_count | output | CNT_W | Count of the selected cell |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is a vote and a read of the same cell. The bench presents a pixel while the read port points at a cell that pixel is known to hit. It expects the old count before the edge and the incremented count after it.

The second pair is downstream taking a result while upstream offers a new pixel. Long sweeps with downstream always ready keep the machine streaming in FULL, and every forward result and every counter is compared with an arithmetic model. A held-off downstream then confirms that the waiting pixel neither votes nor disturbs the forward data until it is released.

// File: rtl/circ_pkg.sv
package circ_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pe_state_t;

    localparam int N_BANKS    = 8;
    localparam int BANK_SEL_W = 3;

endpackage

// File: rtl/circ_rotor.sv
module circ_rotor #(
    parameter int PIX_W = 5,
    parameter int SHIFT = 2,
    localparam int RW   = PIX_W + 2
) (
    input  logic [PIX_W-1:0]     px,
    input  logic [PIX_W-1:0]     py,
    input  logic [PIX_W-1:0]     cx,
    input  logic [PIX_W-1:0]     cy,
    output logic signed [RW-1:0] ra,
    output logic signed [RW-1:0] rc
);

    localparam int SQ_SH = 2 * SHIFT + 1;

    logic signed [RW-1:0] dx;
    logic signed [RW-1:0] dy;

    // centre-relative offsets
    assign dx = $signed({2'b00, px}) - $signed({2'b00, cx});
    assign dy = $signed({2'b00, py}) - $signed({2'b00, cy});

    // one scaling-free rotation step: cos ~ 1 - 2^-(2s+1), sin ~ 2^-s
    assign ra = dx - (dx >>> SQ_SH) + (dy >>> SHIFT);
    assign rc = dy - (dy >>> SQ_SH) - (dx >>> SHIFT);

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import circ_pkg::*;
#(
    parameter int RW      = 7,
    parameter int DEPTH   = 12,
    parameter int BIN_SH  = 2,
    localparam int AW     = RW + 1,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic signed [RW-1:0]             ra,
    input  logic signed [RW-1:0]             rc,
    output logic [N_BANKS-1:0]               hit,
    output logic [N_BANKS-1:0][IDX_W-1:0]    idx
);

    logic [AW-1:0]              ea;
    logic [AW-1:0]              ec;
    logic [3:0][AW-1:0]         base;
    logic [N_BANKS-1:0][AW-1:0] rad;

    assign ea = {ra[RW-1], ra};
    assign ec = {rc[RW-1], rc};

    // the two rotor outputs and the two diagonal (scaled) radii
    assign base[0] = ea;
    assign base[1] = ea + ec;
    assign base[2] = ec;
    assign base[3] = ec - ea;

    for (genvar g = 0; g < N_BANKS; g++) begin : g_sub
        logic [AW-1:0] q;
        if (g < 4) begin : g_direct
            assign rad[g] = base[g];
        end else begin : g_mirror
            assign rad[g] = -base[g-4];
        end
        assign q      = rad[g] >> BIN_SH;
        assign hit[g] = ~rad[g][AW-1] && (q < AW'(DEPTH));
        assign idx[g] = q[IDX_W-1:0];
    end

endmodule

// File: rtl/circ_vote_bank.sv
module circ_vote_bank #(
    parameter int DEPTH  = 12,
    parameter int CNT_W  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vote_en,
    input  logic [IDX_W-1:0] vote_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);

    logic [CNT_W-1:0] cnt [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt[i] <= '0;
            end
        end else if (vote_en && (cnt[vote_idx] != {CNT_W{1'b1}})) begin
            cnt[vote_idx] <= cnt[vote_idx] + 1'b1;
        end
    end

    assign rd_cnt = (int'(rd_idx) < DEPTH) ? cnt[rd_idx] : '0;

    // R6
    vote_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_en |-> int'(vote_idx) < DEPTH);

    for (genvar c = 0; c < DEPTH; c++) begin : g_cell_chk
        // R7
        cell_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[c] != $past(cnt[c])) |-> ((cnt[c] - $past(cnt[c])) == CNT_W'(1)));
        // R8
        cell_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cnt[c]) == {CNT_W{1'b1}}) |-> (cnt[c] == {CNT_W{1'b1}}));
    end

endmodule

// File: rtl/circ_radius_pe.sv
module circ_radius_pe
    import circ_pkg::*;
#(
    parameter int PIX_W  = 5,
    parameter int SHIFT  = 2,
    parameter int DEPTH  = 12,
    parameter int BIN_SH = 2,
    parameter int CNT_W  = 4,
    localparam int RW    = PIX_W + 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIX_W-1:0]      pix_x,
    input  logic [PIX_W-1:0]      pix_y,
    input  logic                  pix_valid,
    output logic                  pix_ready,
    input  logic [PIX_W-1:0]      ctr_x,
    input  logic [PIX_W-1:0]      ctr_y,
    output logic signed [RW-1:0]  fwd_x,
    output logic signed [RW-1:0]  fwd_y,
    output logic                  fwd_valid,
    input  logic                  fwd_ready,
    input  logic [BANK_SEL_W-1:0] rd_bank,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [CNT_W-1:0]      rd_count
);

    pe_state_t state_q;
    pe_state_t state_d;
    logic      take;

    logic signed [RW-1:0]            ra;
    logic signed [RW-1:0]            rc;
    logic [N_BANKS-1:0]              hit;
    logic [N_BANKS-1:0][IDX_W-1:0]   idx;
    logic [N_BANKS-1:0][CNT_W-1:0]   bank_cnt;

    circ_rotor #(
        .PIX_W (PIX_W),
        .SHIFT (SHIFT)
    ) rotor_i (
        .px (pix_x),
        .py (pix_y),
        .cx (ctr_x),
        .cy (ctr_y),
        .ra (ra),
        .rc (rc)
    );

    circ_addr_gen #(
        .RW     (RW),
        .DEPTH  (DEPTH),
        .BIN_SH (BIN_SH)
    ) addr_i (
        .ra  (ra),
        .rc  (rc),
        .hit (hit),
        .idx (idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (pix_valid)                state_d = ST_FULL;
            ST_FULL:  if (fwd_ready && !pix_valid)  state_d = ST_EMPTY;
            default:                                state_d = ST_EMPTY;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        pix_ready = 1'b0;
        fwd_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: pix_ready = 1'b1;
            ST_FULL: begin
                fwd_valid = 1'b1;
                pix_ready = fwd_ready;
            end
            default: ;
        endcase
    end

    assign take = pix_valid && pix_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_x <= '0;
            fwd_y <= '0;
        end else if (take) begin
            fwd_x <= ra;
            fwd_y <= rc;
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        circ_vote_bank #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .vote_en  (take && hit[b]),
            .vote_idx (idx[b]),
            .rd_idx   (rd_idx),
            .rd_cnt   (bank_cnt[b])
        );
    end

    assign rd_count = bank_cnt[rd_bank];

    // R9
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_x) && $stable(fwd_y)));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |-> !pix_ready);

    // R10
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fwd_valid) |-> ($past(fwd_ready) && !$past(pix_valid)));

    // R10
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> fwd_valid);

endmodule

// File: tb/circ_radius_pe_tb_top.sv
module circ_radius_pe_tb_top;

    localparam int PIX_W  = 5;
    localparam int SHIFT  = 2;
    localparam int DEPTH  = 12;
    localparam int BIN_SH = 2;
    localparam int CNT_W  = 4;
    localparam int RW     = PIX_W + 2;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [PIX_W-1:0]     pix_x = '0;
    logic [PIX_W-1:0]     pix_y = '0;
    logic                 pix_valid = 1'b0;
    logic                 pix_ready;
    logic [PIX_W-1:0]     ctr_x = '0;
    logic [PIX_W-1:0]     ctr_y = '0;
    logic signed [RW-1:0] fwd_x;
    logic signed [RW-1:0] fwd_y;
    logic                 fwd_valid;
    logic                 fwd_ready = 1'b1;
    logic [2:0]           rd_bank = '0;
    logic [IDX_W-1:0]     rd_idx = '0;
    logic [CNT_W-1:0]     rd_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int model [8][DEPTH];

    always #5ns clk = ~clk;

    circ_radius_pe #(
        .PIX_W (PIX_W), .SHIFT (SHIFT), .DEPTH (DEPTH),
        .BIN_SH (BIN_SH), .CNT_W (CNT_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .pix_x (pix_x), .pix_y (pix_y), .pix_valid (pix_valid), .pix_ready (pix_ready),
        .ctr_x (ctr_x), .ctr_y (ctr_y),
        .fwd_x (fwd_x), .fwd_y (fwd_y), .fwd_valid (fwd_valid), .fwd_ready (fwd_ready),
        .rd_bank (rd_bank), .rd_idx (rd_idx), .rd_count (rd_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_a(input int x, input int y, input int cx, input int cy);
        int dx = x - cx;
        int dy = y - cy;
        return dx - (dx >>> (2 * SHIFT + 1)) + (dy >>> SHIFT);
    endfunction

    function automatic int exp_c(input int x, input int y, input int cx, input int cy);
        int dx = x - cx;
        int dy = y - cy;
        return dy - (dy >>> (2 * SHIFT + 1)) - (dx >>> SHIFT);
    endfunction

    // R3 bank order
    function automatic int radius_of(input int bank, input int a, input int c);
        case (bank)
            0: return a;
            1: return a + c;
            2: return c;
            3: return c - a;
            4: return -a;
            5: return -(a + c);
            6: return -c;
            default: return -(c - a);
        endcase
    endfunction

    // R4 R5 R6 R8
    task automatic model_vote(input int x, input int y);
        int a = exp_a(x, y, int'(ctr_x), int'(ctr_y));
        int c = exp_c(x, y, int'(ctr_x), int'(ctr_y));
        for (int b = 0; b < 8; b++) begin
            int r = radius_of(b, a, c);
            if (r >= 0 && (r >> BIN_SH) < DEPTH && model[b][r >> BIN_SH] < CMAX)
                model[b][r >> BIN_SH]++;
        end
    endtask

    function automatic int read_cell(input int b, input int i);
        return 0;
    endfunction

    task automatic peek(input int b, input int i, output int v);
        rd_bank = 3'(b);
        rd_idx  = IDX_W'(i);
        #1ns;
        v = int'(rd_count);
    endtask

    // present one pixel with downstream ready; check forward result (R2)
    task automatic push(input int x, input int y);
        pix_x = PIX_W'(x);
        pix_y = PIX_W'(y);
        pix_valid = 1'b1;
        @(posedge clk);
        model_vote(x, y);
        @(negedge clk);
        chk("R2 fwd_x", int'(fwd_x), exp_a(x, y, int'(ctr_x), int'(ctr_y)));
        chk("R2 fwd_y", int'(fwd_y), exp_c(x, y, int'(ctr_x), int'(ctr_y)));
        chk("R10 stream fwd_valid", int'(fwd_valid), 1);
    endtask

    task automatic go_idle();
        pix_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        int v;
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                peek(b, i, v);
                chk(req, v, model[b][i]);
            end
        end
    endtask

    initial begin
        #2ms;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int v0;
        int a;
        int c;
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < DEPTH; i++) model[b][i] = 0;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pix_ready", int'(pix_ready), 1);
        chk("R1 fwd_valid", int'(fwd_valid), 0);
        check_all("R1 counter zero");

        // R5: ra negative (-5), its mirror (bank 4) votes radius 5 -> cell 1
        ctr_x = 5'd16;
        ctr_y = 5'd16;
        push(10, 16);
        go_idle();
        // R10 drain to EMPTY
        chk("R10 drain fwd_valid", int'(fwd_valid), 0);
        chk("R10 drain pix_ready", int'(pix_ready), 1);
        peek(4, 1, v);
        chk("R5 mirror bank4 cell1", v, 1);
        for (int i = 0; i < DEPTH; i++) begin
            peek(0, i, v);
            chk("R5 negative radius bank0 empty", v, 0);
        end

        // R6: radius 62 in bank 1 exceeds the last cell
        ctr_x = 5'd0;
        ctr_y = 5'd0;
        push(31, 31);
        go_idle();
        check_all("R3/R4/R5/R6 after corners");

        // R7: vote and read of the same cell in one cycle; pixel (6,2): ra=6 -> bank0 cell1
        a = exp_a(6, 2, 0, 0);
        peek(0, a >> BIN_SH, v0);
        pix_x = 5'd6;
        pix_y = 5'd2;
        pix_valid = 1'b1;
        #2ns;
        v = int'(rd_count);
        chk("R7 same-cycle read old", v, v0);
        @(posedge clk);
        model_vote(6, 2);
        @(negedge clk);
        pix_valid = 1'b0;
        #1ns;
        chk("R7 next-cycle read new", int'(rd_count), v0 + 1);
        @(negedge clk);

        // main sweep, centre (13,18), back-to-back stream
        ctr_x = 5'd13;
        ctr_y = 5'd18;
        for (int x = 0; x < 32; x += 3) begin
            for (int y = 0; y < 32; y += 3) push(x, y);
        end
        go_idle();
        check_all("R3/R4/R5/R6/R8 sweep one");

        // second sweep, centre at a corner
        ctr_x = 5'd31;
        ctr_y = 5'd0;
        for (int x = 1; x < 32; x += 5) begin
            for (int y = 2; y < 32; y += 4) push(x, y);
        end
        go_idle();
        check_all("R3/R4/R5/R6/R8 sweep two");

        // R8 saturation: pixel (4,0) centre (0,0) -> ra=4 -> bank0 cell1
        ctr_x = 5'd0;
        ctr_y = 5'd0;
        for (int k = 0; k < 20; k++) push(4, 0);
        go_idle();
        peek(0, 1, v);
        chk("R8 saturated cell", v, CMAX);

        // R9 stall: load one result, then hold downstream off
        push(3, 3);
        a = exp_a(3, 3, 0, 0);
        c = exp_c(3, 3, 0, 0);
        fwd_ready = 1'b0;
        pix_x = 5'd8;
        pix_y = 5'd0;
        pix_valid = 1'b1;
        peek(0, exp_a(8, 0, 0, 0) >> BIN_SH, v0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 stalled pix_ready", int'(pix_ready), 0);
            chk("R9 held fwd_x", int'(fwd_x), a);
            chk("R9 held fwd_y", int'(fwd_y), c);
            chk("R10 stall fwd_valid", int'(fwd_valid), 1);
            peek(0, exp_a(8, 0, 0, 0) >> BIN_SH, v);
            chk("R9 no vote while stalled", v, v0);
        end
        fwd_ready = 1'b1;
        @(posedge clk);
        model_vote(8, 0);
        @(negedge clk);
        chk("R9 released fwd_x", int'(fwd_x), exp_a(8, 0, 0, 0));
        go_idle();
        check_all("R9/R4 after stall");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule